// File: doc/BRIEF.md
# Cluster Product-Term Steering Unit

This block takes the five product-term signals of one logic cluster and decides, term by term, whether each one feeds the cluster's OR sum or goes to a control line of its own. Each term slot has exactly one fixed alternate role. Slot 0 can supply the single-term input to the macrocell XOR/OR path. Slot 1 can supply a per-macrocell clock. Slot 2 can supply either an initialization or a clock enable. Slot 3 can supply a second initialization. Slot 4 can supply an output enable for the I/O cell. When a term is diverted to its control role, it is removed from the OR sum.

The OR sum is driven on two outputs. One is a fast path into the I/O cell. The other feeds the downstream cluster allocator. The steering itself is purely combinational. The only state is a six-bit configuration word, which is loaded through a simple write strobe. It is set once at start-up and then left unchanged while the cluster operates. The AND array that forms the terms, the macrocell flip-flop and the I/O cell all sit outside this block.

Top module: `ptsteer_cluster`

## Requirements
- R1: After reset the configuration word is all zero: every term is in logic mode and the slot-2 role bit selects initialization.
- R2: `sum_fast` is the OR of those bits of `pt_in` whose divert bit (`cfg_wdata[i]` for term i) is 0. A term with its divert bit at 1 contributes 0.
- R3: `sum_alloc` always equals `sum_fast`.
- R4: `xor_term` equals `pt_in[0]` when term 0 is diverted, and is 0 otherwise.
- R5: `pt_clk` equals `pt_in[1]` when term 1 is diverted, and is 0 otherwise.
- R6: With term 2 diverted and role bit `cfg_wdata[5]` at 0, `pt_init_a` equals `pt_in[2]` and `pt_ce` is held at 1.
- R7: With term 2 diverted and role bit at 1, `pt_ce` equals `pt_in[2]` and `pt_init_a` is held at 0.
- R8: `pt_init_b` equals `pt_in[3]` when term 3 is diverted, and is 0 otherwise.
- R9: `pt_oe` equals `pt_in[4]` when term 4 is diverted, and is 0 otherwise.
- R10: A word on `cfg_wdata` is captured at the rising clock edge where `cfg_we` is 1 and steers from the next cycle on. While `cfg_we` is 0, changes on `cfg_wdata` have no effect.
- R11: While term 2 is in logic mode, the role bit has no effect: `pt_ce` is 1 and `pt_init_a` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Bits 4:0 are the divert bits for terms 4..0; bit 5 is the slot-2 role (1 = clock enable) |
| pt_in | input | 5 | Product terms, bit i is term i |
| sum_fast | output | 1 | OR sum for the I/O fast path |
| sum_alloc | output | 1 | OR sum toward the cluster allocator |
| xor_term | output | 1 | Single-term XOR/OR input from slot 0 |
| pt_clk | output | 1 | Per-macrocell clock from slot 1 |
| pt_init_a | output | 1 | Initialization from slot 2 |
| pt_ce | output | 1 | Clock enable from slot 2, default 1 |
| pt_init_b | output | 1 | Initialization from slot 3 |
| pt_oe | output | 1 | Output enable from slot 4 |

## Verification
The bench loads all 64 configuration words. Under each word it applies every term pattern plus random ones, so a term that leaks into the sum while it is diverted, or a control line that follows the wrong slot, shows up as a sum or control mismatch. The slot-2 role bit is exercised both with that term diverted and with it in logic mode. A design that drove the clock enable low at its idle default would stall the flip-flop, and the bench would see `pt_ce` at 0 where 1 is expected. The bench also changes `cfg_wdata` while the strobe is low and checks the steering is unchanged, which catches a register that loads without the strobe.

// File: rtl/ptsteer_pkg.sv
package ptsteer_pkg;
    localparam int TERMS       = 5;
    localparam int CFG_W       = TERMS + 1;
    localparam int SLOT_XOR    = 0;
    localparam int SLOT_CLK    = 1;
    localparam int SLOT_INITCE = 2;
    localparam int SLOT_INIT   = 3;
    localparam int SLOT_OE     = 4;

    typedef struct packed {
        logic             role_ce;
        logic [TERMS-1:0] divert;
    } steer_cfg_t;

    typedef struct packed {
        logic xor_in;
        logic clk;
        logic init_a;
        logic ce;
        logic init_b;
        logic oe;
    } ctl_bus_t;
endpackage

// File: rtl/ptsteer_cfg.sv
module ptsteer_cfg
    import ptsteer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output steer_cfg_t       cfg_q
);
    steer_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (we) cfg_d = steer_cfg_t'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));
    assert_cfg_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q == steer_cfg_t'($past(wdata))));
endmodule

// File: rtl/ptsteer_lane.sv
module ptsteer_lane (
    input  logic term,
    input  logic divert,
    output logic sum_part,
    output logic ctl_val
);
    always_comb begin
        sum_part = term & ~divert;
        ctl_val  = term &  divert;
    end
endmodule

// File: rtl/ptsteer_ctlmap.sv
module ptsteer_ctlmap
    import ptsteer_pkg::*;
(
    input  logic [TERMS-1:0] ctl_val,
    input  logic [TERMS-1:0] divert,
    input  logic             role_ce,
    output ctl_bus_t         bus
);
    always_comb begin
        bus        = '0;
        bus.ce     = 1'b1;
        bus.xor_in = ctl_val[SLOT_XOR];
        bus.clk    = ctl_val[SLOT_CLK];
        bus.init_b = ctl_val[SLOT_INIT];
        bus.oe     = ctl_val[SLOT_OE];
        if (divert[SLOT_INITCE]) begin
            if (role_ce) bus.ce     = ctl_val[SLOT_INITCE];
            else         bus.init_a = ctl_val[SLOT_INITCE];
        end
    end
endmodule

// File: rtl/ptsteer_cluster.sv
module ptsteer_cluster
    import ptsteer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [TERMS-1:0] pt_in,
    output logic             sum_fast,
    output logic             sum_alloc,
    output logic             xor_term,
    output logic             pt_clk,
    output logic             pt_init_a,
    output logic             pt_ce,
    output logic             pt_init_b,
    output logic             pt_oe
);
    steer_cfg_t       cfg_q;
    logic [TERMS-1:0] sum_parts;
    logic [TERMS-1:0] ctl_vals;
    ctl_bus_t         bus;
    logic             or_sum;

    ptsteer_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    for (genvar i = 0; i < TERMS; i++) begin : g_lane
        ptsteer_lane u_lane (
            .term     (pt_in[i]),
            .divert   (cfg_q.divert[i]),
            .sum_part (sum_parts[i]),
            .ctl_val  (ctl_vals[i])
        );
    end

    ptsteer_ctlmap u_map (
        .ctl_val (ctl_vals),
        .divert  (cfg_q.divert),
        .role_ce (cfg_q.role_ce),
        .bus     (bus)
    );

    always_comb begin
        or_sum    = |sum_parts;
        sum_fast  = or_sum;
        sum_alloc = or_sum;
        xor_term  = bus.xor_in;
        pt_clk    = bus.clk;
        pt_init_a = bus.init_a;
        pt_ce     = bus.ce;
        pt_init_b = bus.init_b;
        pt_oe     = bus.oe;
    end

    assert_sum_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pt_in & ~cfg_q.divert) == '0) |-> !sum_fast);
    assert_sum_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pt_in & ~cfg_q.divert) != '0) |-> sum_alloc);
    assert_xor_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.divert[SLOT_XOR] |-> !xor_term);
    assert_clk_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.divert[SLOT_CLK] |-> (pt_clk == pt_in[SLOT_CLK]));
    assert_init_ce_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pt_init_a |-> pt_ce);
    assert_ce_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.divert[SLOT_INITCE] && cfg_q.role_ce) |-> (pt_ce == pt_in[SLOT_INITCE]));
    assert_init_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.divert[SLOT_INIT] |-> (pt_init_b == pt_in[SLOT_INIT]));
    assert_oe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.divert[SLOT_OE] |-> !pt_oe);
    assert_role_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.divert[SLOT_INITCE] |-> (pt_ce && !pt_init_a));
endmodule

// File: tb/sim_ptsteer_cluster.sv
module sim_ptsteer_cluster;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic [4:0] pt_in = '0;
    logic sum_fast, sum_alloc, xor_term, pt_clk, pt_init_a, pt_ce, pt_init_b, pt_oe;

    int vectors = 0;
    int miscompares = 0;
    logic [5:0] model_cfg = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptsteer_cluster u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .pt_in(pt_in), .sum_fast(sum_fast), .sum_alloc(sum_alloc),
        .xor_term(xor_term), .pt_clk(pt_clk), .pt_init_a(pt_init_a),
        .pt_ce(pt_ce), .pt_init_b(pt_init_b), .pt_oe(pt_oe)
    );

    task automatic cmp(input string req, input string name, input logic got, input logic exp);
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %b expected %b (cfg=%b pt=%b)",
                     req, name, got, exp, model_cfg, pt_in);
        end
    endtask

    task automatic apply(input logic [4:0] p, input string phase);
        bit sum_e, d2, rce;
        bit init_a_e, ce_e;
        string r2tag;
        @(negedge clk);
        pt_in = p;
        #1;
        vectors++;
        sum_e = 1'b0;
        for (int i = 0; i < 5; i++)
            if (p[i] && !model_cfg[i]) sum_e = 1'b1;
        d2  = model_cfg[2];
        rce = model_cfg[5];
        init_a_e = 1'b0;
        ce_e     = 1'b1;
        if (!d2)      r2tag = "R11";
        else if (rce) begin r2tag = "R7"; ce_e = p[2]; end
        else          begin r2tag = "R6"; init_a_e = p[2]; end
        cmp({phase, "/R2"}, "sum_fast", sum_fast, sum_e);
        cmp({phase, "/R3"}, "sum_alloc", sum_alloc, sum_e);
        cmp({phase, "/R4"}, "xor_term", xor_term, model_cfg[0] ? p[0] : 1'b0);
        cmp({phase, "/R5"}, "pt_clk", pt_clk, model_cfg[1] ? p[1] : 1'b0);
        cmp({phase, "/", r2tag}, "pt_init_a", pt_init_a, init_a_e);
        cmp({phase, "/", r2tag}, "pt_ce", pt_ce, ce_e);
        cmp({phase, "/R8"}, "pt_init_b", pt_init_b, model_cfg[3] ? p[3] : 1'b0);
        cmp({phase, "/R9"}, "pt_oe", pt_oe, model_cfg[4] ? p[4] : 1'b0);
    endtask

    task automatic write_cfg(input logic [5:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        model_cfg = w;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset word is all logic mode
        for (int p = 0; p < 32; p++) apply(5'(p), "R1");
        for (int c = 0; c < 64; c++) begin
            write_cfg(6'(c));
            for (int p = 0; p < 32; p++) apply(5'(p), "R10");
            for (int k = 0; k < 16; k++) apply(5'($urandom), "RND");
            // R10: write data moves while strobe is low; steering must not change
            @(negedge clk);
            cfg_wdata = ~6'(c);
            repeat (2) @(negedge clk);
            for (int p = 0; p < 32; p++) apply(5'(p), "R10");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule